// File: doc/BRIEF.md
# Buffer Flush Sideband Handshake

This controller sits in a host bridge. It serves two active-low sideband request lines that come from a legacy expansion-bus bridge. Each clock it decodes the pair of lines into a request mode.

- **Flush mode:** it tells the bridge to drain the writes posted toward PCI.
- **Full-drain mode:** it drains every buffer, the request queues and the in-order queue, and it keeps ownership of the host bus.

Write posting is blocked while either mode is active. The controller watches empty indications from the buffers and queues that the current mode needs. When all of them are empty it asserts an active-low acknowledge. The acknowledge then stays asserted, without regard to the empty flags, until the request is withdrawn or changed.

All outputs are registered. The request pair is sampled on every rising edge. The drain commands, the posting block and the bus hold follow the mode sampled on the previous edge. If the request code changes, the wait restarts against the requirements of the new mode.

Top module: `flush_handshake`

## Requirements
- R1: While `rst` is high on a clock edge, `ack_n` goes to 1 and `flush_pci_wb`, `flush_all`, `post_block` and `bus_hold` go to 0.
- R2: The request code is {~flush_in_n, ~latency_req_n}. Code 00 means no action: one edge after it is sampled, all command outputs are 0 and `ack_n` is 1.
- R3: Code 01 is reserved and is handled exactly like 00: no command output is asserted and `ack_n` stays 1.
- R4: Code 10 (flush mode) sets `flush_pci_wb` and `post_block` to 1 one edge after it is sampled, and keeps `flush_all` and `bus_hold` at 0. Its acknowledge needs only `pci_wb_empty`.
- R5: Code 11 (full-drain mode) sets `flush_pci_wb`, `flush_all`, `post_block` and `bus_hold` to 1 one edge after it is sampled. Its acknowledge needs all of these at 1: `pci_wb_empty`, `host_buf_empty`, every bit of `rq_empty`, and `ioq_empty`.
- R6: `ack_n` falls at the first edge, at least two edges after the code appears, at which the code is unchanged and the needed empty flags are all 1. It never falls earlier.
- R7: Once `ack_n` is 0, it stays 0 while the same active code is held, even if the empty flags drop.
- R8: The first edge that samples code 00 or 01 sets `ack_n` to 1 and clears `bus_hold` at that same edge.
- R9: A change between active codes sets `ack_n` to 1 at the edge that samples the new code. `ack_n` falls again only once the new mode's empty flags are met.
- R10: `post_block` is 1 whenever `ack_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_in_n | input | 1 | Active-low flush request (high bit of the code) |
| latency_req_n | input | 1 | Active-low access-latency request (low bit of the code) |
| pci_wb_empty | input | 1 | Writes posted toward PCI are drained |
| host_buf_empty | input | 1 | All other data buffers are drained |
| rq_empty | input | NQ | One empty flag per request queue |
| ioq_empty | input | 1 | In-order queue is empty |
| flush_pci_wb | output | 1 | Command: drain writes posted toward PCI |
| flush_all | output | 1 | Command: drain all buffers, request queues and the in-order queue |
| post_block | output | 1 | Disables new write posting |
| bus_hold | output | 1 | Keeps host bus ownership |
| ack_n | output | 1 | Active-low acknowledge |

## Verification
Two events can fall on the same edge: the request code changing and the empty flags becoming satisfied. The bench provokes this by switching from flush mode to full-drain mode while every empty flag is already 1. It also switches partway through a drain whose flags are not yet met. In both cases it expects `ack_n` to stay 1 at the switching edge and to fall only one edge later. Separately, the bench drops the request in the cycle after the acknowledge and confirms that the acknowledge and the bus hold both clear at that single edge.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PCIW = 2'd1,
    MODE_FULL = 2'd2
  } mode_e;

endpackage

// File: rtl/fsb_req_decode.sv
module fsb_req_decode
  import fsb_pkg::*;
(
  input  logic  flush_in_n,
  input  logic  latency_req_n,
  output mode_e mode_d
);

  logic [1:0] code;

  assign code = {~flush_in_n, ~latency_req_n};

  always_comb begin
    unique case (code)
      2'b10:   mode_d = MODE_PCIW;
      2'b11:   mode_d = MODE_FULL;
      default: mode_d = MODE_IDLE;  // 00 and reserved 01
    endcase
  end

endmodule

// File: rtl/fsb_drain_track.sv
module fsb_drain_track
  import fsb_pkg::*;
#(
  parameter int NQ = 2
) (
  input  mode_e         mode_q,
  input  logic          pci_wb_empty,
  input  logic          host_buf_empty,
  input  logic [NQ-1:0] rq_empty,
  input  logic          ioq_empty,
  output logic          need_met
);

  logic [NQ:0] rq_chain;

  assign rq_chain[0] = 1'b1;

  for (genvar g = 0; g < NQ; g++) begin : g_rq
    assign rq_chain[g+1] = rq_chain[g] & rq_empty[g];
  end

  always_comb begin
    unique case (mode_q)
      MODE_PCIW: need_met = pci_wb_empty;
      MODE_FULL: need_met = pci_wb_empty & host_buf_empty & rq_chain[NQ] & ioq_empty;
      default:   need_met = 1'b0;
    endcase
  end

endmodule

// File: rtl/fsb_ack_ctrl.sv
module fsb_ack_ctrl
  import fsb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_d,
  input  logic  need_met,
  output mode_e mode_q,
  output logic  ack_n,
  output logic  flush_pci_wb,
  output logic  flush_all,
  output logic  post_block,
  output logic  bus_hold
);

  logic active_d;
  logic same_d;

  assign active_d = (mode_d != MODE_IDLE);
  assign same_d   = (mode_d == mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_IDLE;
      ack_n        <= 1'b1;
      flush_pci_wb <= 1'b0;
      flush_all    <= 1'b0;
      post_block   <= 1'b0;
      bus_hold     <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      ack_n        <= !(active_d && same_d && (!ack_n || need_met));
      flush_pci_wb <= active_d;
      flush_all    <= (mode_d == MODE_FULL);
      post_block   <= active_d;
      bus_hold     <= (mode_d == MODE_FULL);
    end
  end

  // R6
  ack_needs_met_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> $past(need_met));

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && mode_d != MODE_IDLE && mode_d == mode_q) |=> !ack_n);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_d == MODE_IDLE) |=> (ack_n && !bus_hold));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_d != mode_q) |=> ack_n);

  // R10
  post_block_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> post_block);

endmodule

// File: rtl/flush_handshake.sv
module flush_handshake
  import fsb_pkg::*;
#(
  parameter int NQ = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_in_n,
  input  logic          latency_req_n,
  input  logic          pci_wb_empty,
  input  logic          host_buf_empty,
  input  logic [NQ-1:0] rq_empty,
  input  logic          ioq_empty,
  output logic          flush_pci_wb,
  output logic          flush_all,
  output logic          post_block,
  output logic          bus_hold,
  output logic          ack_n
);

  mode_e mode_d;
  mode_e mode_q;
  logic  need_met;

  fsb_req_decode u_dec (
    .flush_in_n    (flush_in_n),
    .latency_req_n (latency_req_n),
    .mode_d        (mode_d)
  );

  fsb_drain_track #(.NQ(NQ)) u_trk (
    .mode_q         (mode_q),
    .pci_wb_empty   (pci_wb_empty),
    .host_buf_empty (host_buf_empty),
    .rq_empty       (rq_empty),
    .ioq_empty      (ioq_empty),
    .need_met       (need_met)
  );

  fsb_ack_ctrl u_ack (
    .clk          (clk),
    .rst          (rst),
    .mode_d       (mode_d),
    .need_met     (need_met),
    .mode_q       (mode_q),
    .ack_n        (ack_n),
    .flush_pci_wb (flush_pci_wb),
    .flush_all    (flush_all),
    .post_block   (post_block),
    .bus_hold     (bus_hold)
  );

  // R5
  hold_implies_full_drain_chk: assert property (@(posedge clk) disable iff (rst)
    bus_hold |-> (flush_all && flush_pci_wb));

endmodule

// File: tb/flush_handshake_tb.sv
module flush_handshake_tb;

  localparam int NQ = 2;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          flush_in_n, latency_req_n;
  logic          pci_wb_empty, host_buf_empty, ioq_empty;
  logic [NQ-1:0] rq_empty;
  logic          flush_pci_wb, flush_all, post_block, bus_hold, ack_n;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flush_handshake #(.NQ(NQ)) u_dut (
    .clk(clk), .rst(rst),
    .flush_in_n(flush_in_n), .latency_req_n(latency_req_n),
    .pci_wb_empty(pci_wb_empty), .host_buf_empty(host_buf_empty),
    .rq_empty(rq_empty), .ioq_empty(ioq_empty),
    .flush_pci_wb(flush_pci_wb), .flush_all(flush_all),
    .post_block(post_block), .bus_hold(bus_hold), .ack_n(ack_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // expected outputs vector {flush_pci_wb, flush_all, post_block, bus_hold, ack_n}
  task automatic chk_all(input string req, input logic [4:0] exp);
    chk({req, " flush_pci_wb"}, flush_pci_wb, exp[4]);
    chk({req, " flush_all"},    flush_all,    exp[3]);
    chk({req, " post_block"},   post_block,   exp[2]);
    chk({req, " bus_hold"},     bus_hold,     exp[1]);
    chk({req, " ack_n"},        ack_n,        exp[0]);
  endtask

  // inputs change at negedge; one call = one rising edge, then sample at negedge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_code(input logic [1:0] c);
    flush_in_n    = ~c[1];
    latency_req_n = ~c[0];
  endtask

  task automatic set_empty(input logic p, input logic h, input logic [NQ-1:0] q, input logic io);
    pci_wb_empty = p; host_buf_empty = h; rq_empty = q; ioq_empty = io;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    set_code(2'b11);
    set_empty(1'b1, 1'b1, '1, 1'b1);
    step(3);
    chk_all("R1 reset", 5'b00001);
    set_code(2'b00);
    step(1);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_idle;
    set_code(2'b00);
    set_empty(1'b1, 1'b1, '1, 1'b1);
    step(3);
    chk_all("R2 idle", 5'b00001);
  endtask

  task automatic t_reserved;
    set_code(2'b01);
    step(1);
    chk_all("R3 reserved first edge", 5'b00001);
    step(3);
    chk_all("R3 reserved held", 5'b00001);
    set_code(2'b00);
    step(1);
  endtask

  task automatic t_flush_mode;
    set_empty(1'b0, 1'b0, '0, 1'b0);
    set_code(2'b10);
    step(1);
    chk_all("R4 flush outputs", 5'b10101);
    step(3);
    chk("R6 no ack before empty", ack_n, 1'b1);
    pci_wb_empty = 1'b1;  // only this flag needed
    step(1);
    chk("R4 ack on pci empty only", ack_n, 1'b0);
    chk("R10 posting blocked with ack", post_block, 1'b1);
    pci_wb_empty = 1'b0;
    step(3);
    chk("R7 ack held", ack_n, 1'b0);
    set_code(2'b00);
    step(1);
    chk_all("R8 release", 5'b00001);
  endtask

  task automatic t_full_fast;
    set_empty(1'b1, 1'b1, '1, 1'b1);
    set_code(2'b11);
    step(1);
    chk_all("R5 full outputs", 5'b11111);
    step(1);
    chk("R6 ack at second edge", ack_n, 1'b0);
    set_code(2'b01);
    step(1);
    chk("R8 ack release on reserved", ack_n, 1'b1);
    chk("R8 bus hold release", bus_hold, 1'b0);
    chk("R3 no posting block", post_block, 1'b0);
  endtask

  task automatic t_full_each;
    set_code(2'b00);
    step(1);
    set_empty(1'b1, 1'b1, 2'b01, 1'b1);
    set_code(2'b11);
    step(4);
    chk("R5 waits on rq_empty[1]", ack_n, 1'b1);
    rq_empty = '1;
    ioq_empty = 1'b0;
    step(2);
    chk("R5 waits on ioq", ack_n, 1'b1);
    ioq_empty = 1'b1;
    host_buf_empty = 1'b0;
    step(2);
    chk("R5 waits on host buffers", ack_n, 1'b1);
    host_buf_empty = 1'b1;
    step(1);
    chk("R5 ack when all empty", ack_n, 1'b0);
    set_code(2'b00);
    step(1);
  endtask

  task automatic t_restart;
    // change of code with flags already met: same-edge collision
    set_empty(1'b1, 1'b1, '1, 1'b1);
    set_code(2'b10);
    step(2);
    chk("R9 flush acked", ack_n, 1'b0);
    set_code(2'b11);
    step(1);
    chk("R9 ack drops at change", ack_n, 1'b1);
    chk("R9 bus hold taken", bus_hold, 1'b1);
    step(1);
    chk("R9 ack after restart", ack_n, 1'b0);
    // change while drain pending, new mode not met
    set_code(2'b00);
    step(1);
    set_empty(1'b0, 1'b1, '1, 1'b0);
    set_code(2'b10);
    step(1);
    set_code(2'b11);
    pci_wb_empty = 1'b1;
    step(1);
    chk("R9 no ack at change edge", ack_n, 1'b1);
    step(3);
    chk("R9 waits new needs", ack_n, 1'b1);
    ioq_empty = 1'b1;
    step(1);
    chk("R9 ack once new needs met", ack_n, 1'b0);
    set_code(2'b00);
    step(1);
    chk_all("R8 final release", 5'b00001);
  endtask

  initial begin
    set_code(2'b00);
    set_empty(1'b0, 1'b0, '0, 1'b0);
    rst = 1'b1;
    t_reset();
    t_idle();
    t_reserved();
    t_flush_mode();
    t_full_fast();
    t_full_each();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule